// File: doc/BRIEF.md
# Two-Register Toy Instruction Executor

This block executes one 8-bit instruction per clock cycle against a file of two 16-bit architectural registers. When the valid strobe is high, the instruction word is split into fields, the named source registers are read, an add or a bitwise AND is formed, and the result is written to the destination register at the next rising clock edge. Fetch, sequencing and memory belong to the surrounding logic. This block only executes the word it is given.

The most significant bit of the word chooses between two field layouts. One layout takes two register sources. The other takes one register source and a small unsigned constant. Opcodes outside the three defined operations leave the register file untouched and raise a one-cycle illegal flag. Both register values are driven on output ports at all times, so a checker or the surrounding logic can observe them.

Top module: `tx_exec`

## Requirements
- R1: Bit 7 of `instr_i` selects the layout. When bit 7 is 0 (register layout), bits 6:3 are the opcode, bit 2 is the destination index, bit 1 is the first source index and bit 0 is the second source index.
- R2: When bit 7 is 1 (constant layout), bits 6:5 are the opcode, bit 4 is the destination index, bit 3 is the source index and bits 2:0 are an unsigned 3-bit constant.
- R3: Register index 0 is the register shown on `reg0_o`, and index 1 is the register shown on `reg1_o`.
- R4: Register-layout opcode 4'b0000 writes the sum of the two sources, modulo 2^16, to the destination. The carry out of bit 15 is dropped.
- R5: Register-layout opcode 4'b0001 writes the bitwise AND of the two sources to the destination.
- R6: Constant-layout opcode 2'b00 writes the source plus the zero-extended constant to the destination. A constant of 3'b111 adds 7. It never subtracts.
- R7: Any other opcode (register layout 4'b0010 to 4'b1111, constant layout 2'b01 to 2'b11) leaves both registers unchanged. It drives `illegal_o` high during that same cycle while `valid_i` is high.
- R8: Sources are read before the write. When the destination is also a source, the operation uses the old value. The new value appears after the rising clock edge.
- R9: A synchronous active-high `rst` clears both registers to 0x0000. It overrides any instruction presented in the same cycle.
- R10: While `valid_i` is low, no register changes and `illegal_o` stays low, whatever `instr_i` holds.
- R11: Starting from reset, the sequence add-constant r0=r0+7, add-constant r1=r0+1, AND r0=r0&r1, add r1=r1+r1 leaves r0=0x0007, then r1=0x0008, then r0=0x0000, then r1=0x0010.
- R12: One instruction changes at most one register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears both registers |
| valid_i | input | 1 | High when `instr_i` holds an instruction to execute this cycle |
| instr_i | input | 8 | Instruction word |
| reg0_o | output | 16 | Current value of register index 0 |
| reg1_o | output | 16 | Current value of register index 1 |
| illegal_o | output | 1 | High during a valid cycle whose opcode is not defined |

## Verification
The bound checker examines every clock cycle for the following:
- the result of each of the three operations, recomputed from the previous register values and the instruction bits;
- register stability when the strobe is low or the opcode is illegal;
- the rule that `illegal_o` is only raised when the strobe is high;
- the rule that at most one register changes.

Some behaviour can only be shown by the bench's scenarios:
- the dropped carry, which needs a value doubled up to bit 15 and past it;
- the reset overriding a valid instruction;
- the ordered reference sequence;
- the exact register contents after the mixed instruction table.

// File: rtl/tx_pkg.sv
package tx_pkg;

    localparam int INSTR_W  = 8;
    localparam int IDX_W    = 1;
    localparam int NUM_REGS = 1 << IDX_W;
    localparam int IMM_W    = 3;
    localparam int RR_OP_W  = 4;
    localparam int IM_OP_W  = 2;

    // Layout selector carried in the top bit of the word
    typedef enum logic {
        FMT_REG = 1'b0,
        FMT_IMM = 1'b1
    } fmt_e;

    // Internal operation after decoding
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_AND  = 2'd1,
        OP_ADDI = 2'd2,
        OP_ILL  = 2'd3
    } op_e;

    localparam logic [RR_OP_W-1:0] RR_ADD  = 4'b0000;
    localparam logic [RR_OP_W-1:0] RR_AND  = 4'b0001;
    localparam logic [IM_OP_W-1:0] IM_ADDI = 2'b00;

    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] rs1;
        logic [IDX_W-1:0] rs2;
        logic [IMM_W-1:0] imm;
    } dec_t;

    function automatic op_e map_reg_op(input logic [RR_OP_W-1:0] code);
        op_e res;
        case (code)
            RR_ADD:  res = OP_ADD;
            RR_AND:  res = OP_AND;
            default: res = OP_ILL;
        endcase
        return res;
    endfunction

    function automatic op_e map_imm_op(input logic [IM_OP_W-1:0] code);
        return (code == IM_ADDI) ? OP_ADDI : OP_ILL;
    endfunction

    function automatic dec_t split_word(input logic [INSTR_W-1:0] w);
        dec_t d;
        if (fmt_e'(w[7]) == FMT_REG) begin
            d.op  = map_reg_op(w[6:3]);
            d.rd  = w[2];
            d.rs1 = w[1];
            d.rs2 = w[0];
            d.imm = '0;
        end else begin
            d.op  = map_imm_op(w[6:5]);
            d.rd  = w[4];
            d.rs1 = w[3];
            d.rs2 = '0;
            d.imm = w[2:0];
        end
        return d;
    endfunction

endpackage

// File: rtl/tx_decode.sv
module tx_decode
    import tx_pkg::*;
(
    input  logic [INSTR_W-1:0] word_i,
    output dec_t               dec_o
);

    always_comb begin
        dec_o = split_word(word_i);
    end

endmodule

// File: rtl/tx_alu.sv
module tx_alu
    import tx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] res_o
);

    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    // The constant is always widened with zeros, never with its top bit
    assign imm_ext = {{PAD_W{1'b0}}, imm_i};

    always_comb begin
        case (op_i)
            OP_ADD:  res_o = a_i + b_i;
            OP_AND:  res_o = a_i & b_i;
            OP_ADDI: res_o = a_i + imm_ext;
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/tx_regfile.sv
module tx_regfile
    import tx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we_i,
    input  logic [IDX_W-1:0]                  wa_i,
    input  logic [DATA_W-1:0]                 wd_i,
    input  logic [IDX_W-1:0]                  ra1_i,
    input  logic [IDX_W-1:0]                  ra2_i,
    output logic [DATA_W-1:0]                 rd1_o,
    output logic [DATA_W-1:0]                 rd2_o,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   q_o
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q_o[g] <= '0;
            end else if (we_i && (wa_i == IDX_W'(g))) begin
                q_o[g] <= wd_i;
            end
        end
    end

    // Reads return the value held before this cycle's write
    assign rd1_o = q_o[ra1_i];
    assign rd2_o = q_o[ra2_i];

endmodule

// File: rtl/tx_exec.sv
module tx_exec
    import tx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic [7:0]         instr_i,
    output logic [DATA_W-1:0]  reg0_o,
    output logic [DATA_W-1:0]  reg1_o,
    output logic               illegal_o
);

    dec_t                            dec;
    logic [DATA_W-1:0]               src_a;
    logic [DATA_W-1:0]               src_b;
    logic [DATA_W-1:0]               result;
    logic                            wr_en;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    tx_decode u_dec (
        .word_i (instr_i),
        .dec_o  (dec)
    );

    tx_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we_i  (wr_en),
        .wa_i  (dec.rd),
        .wd_i  (result),
        .ra1_i (dec.rs1),
        .ra2_i (dec.rs2),
        .rd1_o (src_a),
        .rd2_o (src_b),
        .q_o   (regs)
    );

    tx_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i  (dec.op),
        .a_i   (src_a),
        .b_i   (src_b),
        .imm_i (dec.imm),
        .res_o (result)
    );

    assign wr_en     = valid_i && (dec.op != OP_ILL);
    assign illegal_o = valid_i && (dec.op == OP_ILL);
    assign reg0_o    = regs[0];
    assign reg1_o    = regs[1];

endmodule

// File: rtl/tx_exec_chk.sv
module tx_exec_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [7:0]        instr_i,
    input logic [DATA_W-1:0] reg0_o,
    input logic [DATA_W-1:0] reg1_o,
    input logic              illegal_o
);

    logic is_add;
    logic is_and;
    logic is_addi;

    assign is_add  = valid_i && (instr_i[7:3] == 5'b00000);
    assign is_and  = valid_i && (instr_i[7:3] == 5'b00001);
    assign is_addi = valid_i && (instr_i[7:5] == 3'b100);

    // R4
    add_result_chk: assert property (@(posedge clk) disable iff (rst)
        is_add |=> (($past(instr_i[2]) ? reg1_o : reg0_o) ==
                    DATA_W'(($past(instr_i[1]) ? $past(reg1_o) : $past(reg0_o)) +
                            ($past(instr_i[0]) ? $past(reg1_o) : $past(reg0_o)))));

    // R5
    and_result_chk: assert property (@(posedge clk) disable iff (rst)
        is_and |=> (($past(instr_i[2]) ? reg1_o : reg0_o) ==
                    (($past(instr_i[1]) ? $past(reg1_o) : $past(reg0_o)) &
                     ($past(instr_i[0]) ? $past(reg1_o) : $past(reg0_o)))));

    // R6
    addi_result_chk: assert property (@(posedge clk) disable iff (rst)
        is_addi |=> (($past(instr_i[4]) ? reg1_o : reg0_o) ==
                     DATA_W'(($past(instr_i[3]) ? $past(reg1_o) : $past(reg0_o)) +
                             DATA_W'($past(instr_i[2:0])))));

    // R7
    illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> ($stable(reg0_o) && $stable(reg1_o)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(reg0_o) && $stable(reg1_o)));

    // R10
    illegal_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> valid_i);

    // R12
    one_dest_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> ($stable(reg0_o) || $stable(reg1_o)));

endmodule

bind tx_exec tx_exec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .reg0_o    (reg0_o),
    .reg1_o    (reg1_o),
    .illegal_o (illegal_o)
);

// File: tb/tx_exec_test.sv
module tx_exec_test;

    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 12;

    // {instr, expected r0, expected r1, expected illegal}
    localparam logic [40:0] VEC [NROWS] = '{
        {8'h87, 16'h0007, 16'h0000, 1'b0},  // R11 r0=r0+7
        {8'h91, 16'h0007, 16'h0008, 1'b0},  // R11 r1=r0+1
        {8'h09, 16'h0000, 16'h0008, 1'b0},  // R11 r0=r0&r1
        {8'h07, 16'h0000, 16'h0010, 1'b0},  // R11 r1=r1+r1
        {8'h8F, 16'h0017, 16'h0010, 1'b0},  // R2 r0=r1+7
        {8'h01, 16'h0027, 16'h0010, 1'b0},  // R8 r0=r0+r1
        {8'h17, 16'h0027, 16'h0010, 1'b1},  // R7 reg op 0010
        {8'hA7, 16'h0027, 16'h0010, 1'b1},  // R7 imm op 01
        {8'hE0, 16'h0027, 16'h0010, 1'b1},  // R7 imm op 11
        {8'h7F, 16'h0027, 16'h0010, 1'b1},  // R7 reg op 1111
        {8'h0C, 16'h0027, 16'h0027, 1'b0},  // R5 r1=r0&r0
        {8'h98, 16'h0027, 16'h0027, 1'b0}   // R6 r1=r1+0
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [7:0]  instr_i = 8'h00;
    logic [15:0] reg0_o;
    logic [15:0] reg1_o;
    logic        illegal_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    logic ill_seen;

    tx_exec uut (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (valid_i),
        .instr_i   (instr_i),
        .reg0_o    (reg0_o),
        .reg1_o    (reg1_o),
        .illegal_o (illegal_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, capture illegal_o mid-cycle, return at next falling edge
    task automatic step(input logic v, input logic [7:0] w);
        valid_i = v;
        instr_i = w;
        #1;
        ill_seen = illegal_o;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    function automatic string row_tag(input int i);
        if (i < 4)       return "R11";
        else if (i == 4) return "R2";
        else if (i == 5) return "R8";
        else if (i < 10) return "R7";
        else if (i == 10) return "R5";
        else             return "R6";
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] exp0;
        @(negedge clk);
        do_reset();
        // R9 reset state
        check("R9 r0 after reset", reg0_o, 16'h0000);
        check("R9 r1 after reset", reg1_o, 16'h0000);

        for (int i = 0; i < NROWS; i++) begin
            step(1'b1, VEC[i][40:33]);
            check({row_tag(i), " r0"}, reg0_o, VEC[i][32:17]);
            check({row_tag(i), " r1"}, reg1_o, VEC[i][16:1]);
            check({row_tag(i), " illegal"}, {15'd0, ill_seen}, {15'd0, VEC[i][0]});
        end

        // R10 valid low: legal and illegal words have no effect
        step(1'b0, 8'h87);
        check("R10 r0 idle", reg0_o, 16'h0027);
        check("R10 r1 idle", reg1_o, 16'h0027);
        check("R10 illegal idle legal", {15'd0, ill_seen}, 16'h0000);
        step(1'b0, 8'h7F);
        check("R10 illegal idle bad op", {15'd0, ill_seen}, 16'h0000);
        check("R10 r0 idle bad op", reg0_o, 16'h0027);

        // R9 reset overrides a valid instruction in the same cycle
        rst = 1'b1;
        step(1'b1, 8'h87);
        rst = 1'b0;
        check("R9 r0 reset beats write", reg0_o, 16'h0000);
        check("R9 r1 reset beats write", reg1_o, 16'h0000);

        // R3 index 1 maps to reg1_o only
        step(1'b1, 8'h95);  // r1 = r0 + 5
        check("R3 r1 written", reg1_o, 16'h0005);
        check("R3 r0 untouched", reg0_o, 16'h0000);

        // R4 doubling past bit 15 drops the carry
        step(1'b1, 8'h81);  // r0 = r0 + 1
        exp0 = 16'h0001;
        for (int k = 0; k < 15; k++) begin
            step(1'b1, 8'h00);  // r0 = r0 + r0
            exp0 = exp0 + exp0;
        end
        check("R4 r0 reaches top bit", reg0_o, exp0);
        step(1'b1, 8'h00);
        check("R4 carry dropped", reg0_o, 16'h0000);
        check("R1 r1 untouched by r0 ops", reg1_o, 16'h0005);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule